// File: doc/BRIEF.md
# Interrupt Enable and Pending Bank

This block holds, for each of 114 interrupt lines, one enable flag and one pending flag, and presents the lines that are both pending and enabled as an "eligible" vector to a downstream priority arbiter. Software changes the enable flags over a small register bus: one group of four words only turns lines on, a second group of four words only turns them off, and both groups read back the same enable state. Bus accesses take effect only when the privilege flag accompanies them.

Interrupt sources feed a request vector. A rising edge on a request latches the line's pending flag whether or not the line is enabled, so a masked line keeps its event and becomes eligible the moment software enables it. The arbiter, once it has taken an interrupt, clears the pending flag by pulsing an acknowledge carrying the interrupt number.

Top module: `irq_enable_bank`

## Requirements
- R1: After a synchronous reset every enable flag and every pending flag is 0, `eligible` is all zeros, and `bus_rdata` and `bus_err` are 0.
- R2: A privileged write to set-word k (address 0x100 + 4k, k = 0..3) sets the enable of interrupt 32k + n for every bit n that is 1 in the write data; bits written as 0 leave their enables unchanged, and a set-word write never clears an enable.
- R3: A privileged read of set-word k or clear-word k (address 0x180 + 4k) returns, in bit n, the enable of interrupt 32k + n (1 = enabled); the data appears on `bus_rdata` in the cycle after the one in which `bus_re` is sampled and is 0 in cycles without a read.
- R4: A privileged write to clear-word k clears the enable of interrupt 32k + n for every bit n that is 1; bits written as 0 have no effect, and a clear-word write never sets an enable.
- R5: In word 3 only bits 0 to 17 (interrupts 96 to 113) exist; bits 18 to 31 read as 0 and writes to them are ignored.
- R6: A write with `bus_priv` low changes no enable flag.
- R7: A read with `bus_priv` low returns 0 on `bus_rdata` and raises `bus_err` for exactly the one cycle in which that read's data would appear.
- R8: A 0-to-1 transition of `irq_req[i]` sets pending flag i regardless of the enable; a request held high does not set the flag again after it has been cleared.
- R9: `eligible[i]` equals pending i AND enable i, updated at the same clock edge as the flags; a disabled line is never eligible, and enabling a line whose flag is already pending makes it eligible without a new request.
- R10: `ack_valid` with `ack_id` = i clears pending flag i; if a rising request on line i arrives in the same cycle, the flag stays set; an `ack_id` of 114 or more changes nothing.
- R11: A privileged access to an address outside the two word groups changes no enable, reads 0 and does not raise `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_priv | input | 1 | Access carries privilege |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse for a refused read |
| irq_req | input | 114 | Interrupt request lines |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | 7 | Interrupt number being acknowledged |
| eligible | output | 114 | Pending AND enabled, per line |

## Verification
The assertions check on every cycle that a set-word write never removes an enable and a clear-word write never adds one, that an unprivileged write leaves the enables untouched, that a refused read yields zero data with the error pulse, that a rising request is latched even against a same-cycle acknowledge, and that no disabled line is eligible. Only the bench scenarios can show the address-to-interrupt mapping of each word, the read-back values through both word groups, the hidden bits of the last word, the release of a stored pending event when a line is enabled late, and that a held request does not re-latch after acknowledge.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int unsigned WORD_BITS = 32;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2
  } acc_kind_e;

  function automatic int unsigned words_for(int unsigned n);
    return (n + WORD_BITS - 1) / WORD_BITS;
  endfunction

  function automatic int unsigned idx_bits(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
  import irq_bank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NWORDS   = 4,
  parameter logic [ADDR_W-1:0] SET_BASE = 'h100,
  parameter logic [ADDR_W-1:0] CLR_BASE = 'h180,
  localparam int unsigned IDX_W   = idx_bits(NWORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [IDX_W-1:0]  word
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NWORDS * 4);

  logic [ADDR_W-1:0] set_off, clr_off;
  logic              set_hit, clr_hit, aligned;

  always_comb begin
    set_off = addr - SET_BASE;
    clr_off = addr - CLR_BASE;
    aligned = (addr[1:0] == 2'b00);
    set_hit = aligned && (addr >= SET_BASE) && (set_off < SPAN);
    clr_hit = aligned && (addr >= CLR_BASE) && (clr_off < SPAN);
    kind    = ACC_NONE;
    word    = '0;
    if (set_hit) begin
      kind = ACC_SET;
      word = set_off[IDX_W+1:2];
    end else if (clr_hit) begin
      kind = ACC_CLR;
      word = clr_off[IDX_W+1:2];
    end
  end
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
  import irq_bank_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 114,
  localparam int unsigned NWORDS = words_for(NUM_IRQ),
  localparam int unsigned IDX_W  = idx_bits(NWORDS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_set,
  input  logic                 wr_clr,
  input  logic [IDX_W-1:0]     widx,
  input  logic [WORD_BITS-1:0] wdata,
  output logic [NUM_IRQ-1:0]   en_d,
  output logic [NUM_IRQ-1:0]   en_q
);
  logic [NUM_IRQ-1:0] set_hit, clr_hit;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    localparam int unsigned W = i / WORD_BITS;
    localparam int unsigned B = i % WORD_BITS;
    assign set_hit[i] = wr_set && (widx == IDX_W'(W)) && wdata[B];
    assign clr_hit[i] = wr_clr && (widx == IDX_W'(W)) && wdata[B];
  end

  assign en_d = (en_q | set_hit) & ~clr_hit;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end

  // R1: reset empties the enables
  p_reset_clears_r1: assert property (@(posedge clk) rst |=> (en_q == '0));
  // R2: a set-word write never removes an enable
  p_set_no_clear_r2: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> (($past(en_q) & ~en_q) == '0));
  // R4: a clear-word write never adds an enable
  p_clr_no_set_r4: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> ((en_q & ~$past(en_q)) == '0));
endmodule

// File: rtl/irq_pending_regs.sv
module irq_pending_regs
  import irq_bank_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 114,
  localparam int unsigned ID_W   = idx_bits(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               ack_valid,
  input  logic [ID_W-1:0]    ack_id,
  output logic [NUM_IRQ-1:0] pend_d,
  output logic [NUM_IRQ-1:0] pend_q
);
  logic [NUM_IRQ-1:0] req_q, rise, ack_mask;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_ack
    assign ack_mask[i] = ack_valid && (ack_id == ID_W'(i));
  end

  assign rise   = irq_req & ~req_q;
  assign pend_d = (pend_q & ~ack_mask) | rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= irq_req;
      pend_q <= pend_d;
    end
  end

  // R8, R10: every rising request is latched, even against a same-cycle acknowledge
  p_rise_latched_r10: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));
  // R8: a pending flag appears only after a rising request
  p_set_only_by_edge_r8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((pend_q & ~$past(pend_q) & ~$past(rise)) == '0));
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
  import irq_bank_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 114,
  parameter int unsigned ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] SET_BASE = 'h100,
  parameter logic [ADDR_W-1:0] CLR_BASE = 'h180,
  localparam int unsigned NWORDS = words_for(NUM_IRQ),
  localparam int unsigned IDX_W  = idx_bits(NWORDS),
  localparam int unsigned ID_W   = idx_bits(NUM_IRQ),
  localparam int unsigned PAD_W  = NWORDS * WORD_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_BITS-1:0] bus_wdata,
  input  logic                 bus_we,
  input  logic                 bus_re,
  input  logic                 bus_priv,
  output logic [WORD_BITS-1:0] bus_rdata,
  output logic                 bus_err,
  input  logic [NUM_IRQ-1:0]   irq_req,
  input  logic                 ack_valid,
  input  logic [ID_W-1:0]      ack_id,
  output logic [NUM_IRQ-1:0]   eligible
);
  acc_kind_e          kind;
  logic [IDX_W-1:0]   widx;
  logic               wr_set, wr_clr, rd_hit;
  logic [NUM_IRQ-1:0] en_d, en_q, pend_d, pend_q;
  logic [PAD_W-1:0]   en_pad;
  logic [WORD_BITS-1:0] rd_word;

  irq_bank_decode #(
    .ADDR_W(ADDR_W), .NWORDS(NWORDS), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
  ) u_dec (
    .addr(bus_addr), .kind(kind), .word(widx)
  );

  assign wr_set = bus_we && bus_priv && (kind == ACC_SET);
  assign wr_clr = bus_we && bus_priv && (kind == ACC_CLR);
  assign rd_hit = bus_re && bus_priv && (kind != ACC_NONE);

  irq_enable_regs #(.NUM_IRQ(NUM_IRQ)) u_en (
    .clk(clk), .rst(rst), .wr_set(wr_set), .wr_clr(wr_clr),
    .widx(widx), .wdata(bus_wdata), .en_d(en_d), .en_q(en_q)
  );

  irq_pending_regs #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk(clk), .rst(rst), .irq_req(irq_req), .ack_valid(ack_valid),
    .ack_id(ack_id), .pend_d(pend_d), .pend_q(pend_q)
  );

  always_comb begin
    en_pad = '0;
    en_pad[NUM_IRQ-1:0] = en_q;
    rd_word = en_pad[WORD_BITS*int'(widx) +: WORD_BITS];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      eligible  <= '0;
    end else begin
      bus_rdata <= rd_hit ? rd_word : '0;
      bus_err   <= bus_re && !bus_priv;
      eligible  <= pend_d & en_d;
    end
  end

  // R9: no disabled line is ever eligible
  p_elig_masked_r9: assert property (@(posedge clk) disable iff (rst)
    ((eligible & ~en_q) == '0));
  // R9: eligible never shows a line without its pending flag
  p_elig_pending_r9: assert property (@(posedge clk) disable iff (rst)
    ((eligible & ~pend_q) == '0));
  // R6: an unprivileged write leaves the enables alone
  p_unpriv_write_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !bus_priv) |=> $stable(en_q));
  // R7: a refused read gives zero data and the error pulse
  p_unpriv_read_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_re && !bus_priv) |=> (bus_err && (bus_rdata == '0)));
  // R7: the error pulse never comes without a refused read
  p_err_cause_r7: assert property (@(posedge clk) disable iff (rst)
    !(bus_re && !bus_priv) |=> !bus_err);
endmodule

// File: tb/sim_irq_enable_bank.sv
module sim_irq_enable_bank;
  localparam int N = 114;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic         bus_we = 1'b0, bus_re = 1'b0, bus_priv = 1'b1;
  logic [31:0]  bus_rdata;
  logic         bus_err;
  logic [N-1:0] irq_req = '0;
  logic         ack_valid = 1'b0;
  logic [6:0]   ack_id = '0;
  logic [N-1:0] eligible;

  logic [N-1:0] en_m = '0, pend_m = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_enable_bank u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_priv(bus_priv),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .irq_req(irq_req),
    .ack_valid(ack_valid), .ack_id(ack_id), .eligible(eligible)
  );

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_m(int k);
    logic [31:0] w = '0;
    for (int n = 0; n < 32; n++) if (32*k + n < N) w[n] = en_m[32*k + n];
    return w;
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d, logic p);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_priv = p;
    @(negedge clk);
    bus_we = 1'b0; bus_priv = 1'b1;
  endtask

  task automatic rd(logic [11:0] a, logic p, output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1; bus_priv = p;
    @(negedge clk);
    bus_re = 1'b0; bus_priv = 1'b1;
    d = bus_rdata; e = bus_err;
  endtask

  task automatic set_m(int k, logic [31:0] d);
    for (int n = 0; n < 32; n++) if (d[n] && 32*k + n < N) en_m[32*k + n] = 1'b1;
  endtask

  task automatic clr_m(int k, logic [31:0] d);
    for (int n = 0; n < 32; n++) if (d[n] && 32*k + n < N) en_m[32*k + n] = 1'b0;
  endtask

  task automatic pulse_irq(int i);
    @(negedge clk); irq_req[i] = 1'b1; pend_m[i] = 1'b1;
    @(negedge clk); irq_req[i] = 1'b0;
  endtask

  task automatic do_ack(int id);
    @(negedge clk); ack_valid = 1'b1; ack_id = 7'(id);
    if (id < N) pend_m[id] = 1'b0;
    @(negedge clk); ack_valid = 1'b0;
  endtask

  task automatic chk_elig(string req);
    chk(req, 128'(eligible), 128'(pend_m & en_m));
  endtask

  task automatic t_reset;
    logic [31:0] d; logic e;
    chk("R1 eligible", 128'(eligible), 0);
    chk("R1 rdata", 128'(bus_rdata), 0);
    chk("R1 err", 128'(bus_err), 0);
    for (int k = 0; k < 4; k++) begin
      rd(12'(12'h100 + 4*k), 1'b1, d, e);
      chk("R1 enable word", 128'(d), 0);
    end
  endtask

  task automatic t_set;
    logic [31:0] d; logic e;
    wr(12'h100, 32'h0000_0005, 1'b1); set_m(0, 32'h5);
    rd(12'h100, 1'b1, d, e); chk("R2 word0 set", 128'(d), 128'(word_m(0)));
    wr(12'h100, 32'h0000_0008, 1'b1); set_m(0, 32'h8);
    rd(12'h100, 1'b1, d, e); chk("R2 zero bits no effect", 128'(d), 128'(32'hD));
    wr(12'h108, 32'h8000_0000, 1'b1); set_m(2, 32'h8000_0000);
    rd(12'h188, 1'b1, d, e); chk("R3 readback via clear word", 128'(d), 128'(32'h8000_0000));
    @(negedge clk); chk("R3 rdata idle zero", 128'(bus_rdata), 0);
  endtask

  task automatic t_last;
    logic [31:0] d; logic e;
    wr(12'h10C, 32'hFFFF_FFFF, 1'b1); set_m(3, 32'hFFFF_FFFF);
    rd(12'h10C, 1'b1, d, e); chk("R5 last word bits", 128'(d), 128'(32'h0003_FFFF));
  endtask

  task automatic t_clear;
    logic [31:0] d; logic e;
    wr(12'h18C, 32'h0000_0001, 1'b1); clr_m(3, 32'h1);
    rd(12'h10C, 1'b1, d, e); chk("R4 clear word3 bit0", 128'(d), 128'(32'h0003_FFFE));
    wr(12'h100, 32'h0, 1'b1);
    rd(12'h100, 1'b1, d, e); chk("R2 zero write keeps", 128'(d), 128'(32'hD));
    wr(12'h180, 32'h0000_0004, 1'b1); clr_m(0, 32'h4);
    rd(12'h180, 1'b1, d, e); chk("R4 clear word0 bit2", 128'(d), 128'(32'h9));
  endtask

  task automatic t_priv;
    logic [31:0] d; logic e;
    wr(12'h104, 32'hFFFF_FFFF, 1'b0);
    rd(12'h104, 1'b1, d, e); chk("R6 unpriv write dropped", 128'(d), 0);
    wr(12'h180, 32'hFFFF_FFFF, 1'b0);
    rd(12'h100, 1'b1, d, e); chk("R6 unpriv clear dropped", 128'(d), 128'(32'h9));
    rd(12'h100, 1'b0, d, e);
    chk("R7 unpriv read data", 128'(d), 0);
    chk("R7 unpriv read err", 128'(e), 1);
    @(negedge clk); chk("R7 err one cycle", 128'(bus_err), 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d; logic e;
    wr(12'h110, 32'hFFFF_FFFF, 1'b1);
    wr(12'h0FC, 32'hFFFF_FFFF, 1'b1);
    rd(12'h110, 1'b1, d, e);
    chk("R11 unmapped read", 128'(d), 0);
    chk("R11 unmapped no err", 128'(e), 0);
    rd(12'h104, 1'b1, d, e); chk("R11 enables untouched", 128'(d), 0);
    rd(12'h100, 1'b1, d, e); chk("R11 word0 untouched", 128'(d), 128'(32'h9));
  endtask

  task automatic t_pending;
    pulse_irq(5);
    chk_elig("R8 disabled line latched but not eligible");
    chk("R9 line5 not eligible", 128'(eligible[5]), 0);
    wr(12'h100, 32'h0000_0020, 1'b1); set_m(0, 32'h20);
    chk_elig("R9 late enable exposes pending");
    chk("R9 line5 eligible", 128'(eligible[5]), 1);
    pulse_irq(0);
    chk_elig("R9 enabled line eligible");
    pulse_irq(113);
    chk_elig("R9 top line eligible");
    wr(12'h180, 32'h0000_0001, 1'b1); clr_m(0, 32'h1);
    chk_elig("R9 disable hides pending");
    wr(12'h100, 32'h0000_0001, 1'b1); set_m(0, 32'h1);
    chk_elig("R9 re-enable restores");
  endtask

  task automatic t_ack;
    do_ack(5);
    chk_elig("R10 ack clears");
    do_ack(120);
    chk_elig("R10 out of range ack ignored");
    @(negedge clk);
    irq_req[3] = 1'b1; ack_valid = 1'b1; ack_id = 7'd3; pend_m[3] = 1'b1;
    @(negedge clk); ack_valid = 1'b0;
    chk("R10 same-cycle edge wins", 128'(eligible[3]), 1);
    do_ack(3);
    @(negedge clk);
    chk("R8 held request no relatch", 128'(eligible[3]), 0);
    chk_elig("R8 held request vector");
    irq_req[3] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_set();
    t_last();
    t_clear();
    t_priv();
    t_unmapped();
    t_pending();
    t_ack();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule